// File: doc/BRIEF.md
# Even/Odd Page Frame Selector

This block sits behind the associative lookup of a translation buffer that stores pages in even/odd pairs. Once the lookup has reported whether an entry hit and handed over that entry's page mask and its two half-page records, the block decides which half of the pair the virtual address falls in. It then either produces the physical address together with a capability-permission bit, or reports a translation fault with a code.

The page mask encodes the page size. The block decodes it into the position of the address bit that separates the even page from the odd page. It then builds the physical address by keeping the frame number above that boundary and the virtual offset below it. Loads and stores raise separate refill and invalid fault codes. Only stores can raise the modify fault. One register stage holds all outputs.

Top module: `pfsel_top`

## Requirements
- R1: While reset is high, and on the first cycle after reset, phys_addr is 0, cap_ok is 0, fault is 0 and fault_code is 0 (none).
- R2: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.
- R3: The legal page_mask values are 0x0000, 0x0003, 0x000F, 0x003F, 0x00FF, 0x03FF, 0x0FFF, 0x3FFF and 0xFFFF. Each selects a boundary bit position: 12, 14, 16, 18, 20, 22, 24, 26 and 28 respectively.
- R4: When vaddr at the boundary position is 1, the odd record is used. When it is 0, the even record is used.
- R5: On a fault-free translation, phys_addr equals the selected pfn[23:s-12] placed at bits 35:s, with vaddr[s-1:0] below it and zeros above bit 35. Here s is the boundary position.
- R6: When hit is 0, the block raises a refill fault: code 1 for a load (is_store=0), code 2 for a store.
- R7: When there is a hit with a legal mask and the selected record has valid=0, the block raises an invalid fault: code 3 for a load, code 4 for a store.
- R8: A store to a valid selected record whose dirty bit is 0 raises code 5 (modify). A load never raises code 5.
- R9: An invalid record gives code 3 or 4 even when its dirty bit is also 0.
- R10: On a fault-free translation, cap_ok is the selected cap-store bit for a store and the selected cap-load bit for a load.
- R11: When there is a hit with a page_mask outside the R3 list, the block raises code 6. A miss has priority and still gives code 1 or 2.
- R12: fault is 1 exactly when fault_code is nonzero. Whenever fault is 1, phys_addr and cap_ok are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit | input | 1 | Lookup found a matching entry |
| is_store | input | 1 | 1 = store access, 0 = load access |
| vaddr | input | 64 | Virtual address |
| page_mask | input | 16 | Page mask of the hit entry |
| even_pfn | input | 24 | Frame number, even half |
| even_valid | input | 1 | Valid bit, even half |
| even_dirty | input | 1 | Dirty (writable) bit, even half |
| even_cap_st | input | 1 | Capability-store permission, even half |
| even_cap_ld | input | 1 | Capability-load permission, even half |
| odd_pfn | input | 24 | Frame number, odd half |
| odd_valid | input | 1 | Valid bit, odd half |
| odd_dirty | input | 1 | Dirty (writable) bit, odd half |
| odd_cap_st | input | 1 | Capability-store permission, odd half |
| odd_cap_ld | input | 1 | Capability-load permission, odd half |
| phys_addr | output | 64 | Physical address (0 on fault) |
| cap_ok | output | 1 | Capability permission for this access |
| fault | output | 1 | Translation fault raised |
| fault_code | output | 3 | 0 none, 1/2 refill ld/st, 3/4 invalid ld/st, 5 modify, 6 bad mask |

## Verification
The bench builds the block with its default parameters: a 24-bit frame number, a 12-bit minimum page and nine page sizes. With these values the whole legal mask table is small enough to sweep in full. For every page size, it crosses both halves with load/store and every valid/dirty combination, so each splice boundary and each fault priority is reached. Misses and several illegal masks complete the fault coverage.

// File: rtl/pfsel_pkg.sv
package pfsel_pkg;

    localparam int FRAME_BITS     = 24;
    localparam int MIN_PAGE_SHIFT = 12;
    localparam int SIZE_COUNT     = 9;
    localparam int MASK_BITS      = 16;
    localparam int VA_BITS        = 64;
    localparam int OUT_BITS       = 64;
    localparam int PA_INT_BITS    = FRAME_BITS + MIN_PAGE_SHIFT;
    localparam int SIZE_IDX_BITS  = $clog2(SIZE_COUNT);
    localparam int POS_BITS       = $clog2(VA_BITS);

    typedef enum logic [2:0] {
        FC_NONE       = 3'd0,
        FC_REFILL_LD  = 3'd1,
        FC_REFILL_ST  = 3'd2,
        FC_INVALID_LD = 3'd3,
        FC_INVALID_ST = 3'd4,
        FC_MODIFY     = 3'd5,
        FC_BAD_MASK   = 3'd6
    } fault_e;

    typedef struct packed {
        logic [FRAME_BITS-1:0] pfn;
        logic                  valid;
        logic                  dirty;
        logic                  cap_st;
        logic                  cap_ld;
    } half_t;

    typedef struct packed {
        logic [OUT_BITS-1:0] pa;
        logic                cap;
        fault_e              code;
    } result_t;

    function automatic logic [POS_BITS-1:0] boundary_pos(input logic [SIZE_IDX_BITS-1:0] k);
        return POS_BITS'(MIN_PAGE_SHIFT + 2 * int'(k));
    endfunction

    function automatic logic [MASK_BITS-1:0] mask_for(input int k);
        return MASK_BITS'((32'd1 << (2 * k)) - 32'd1);
    endfunction

endpackage

// File: rtl/pfsel_mask_decode.sv
module pfsel_mask_decode
    import pfsel_pkg::*;
(
    input  logic [MASK_BITS-1:0] mask,
    output logic [POS_BITS-1:0]  pos,
    output logic                 legal
);
    logic [SIZE_COUNT-1:0] match_vec;

    for (genvar k = 0; k < SIZE_COUNT; k++) begin : g_size
        assign match_vec[k] = (mask == mask_for(k));
    end

    always_comb begin
        pos   = POS_BITS'(MIN_PAGE_SHIFT);
        legal = 1'b0;
        for (int k = 0; k < SIZE_COUNT; k++) begin
            if (match_vec[k]) begin
                pos   = boundary_pos(SIZE_IDX_BITS'(k));
                legal = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfsel_half_pick.sv
module pfsel_half_pick
    import pfsel_pkg::*;
(
    input  logic [VA_BITS-1:0]  vaddr,
    input  logic [POS_BITS-1:0] pos,
    input  half_t               even_h,
    input  half_t               odd_h,
    output half_t               chosen
);
    logic odd_sel;

    assign odd_sel = vaddr[pos];
    assign chosen  = odd_sel ? odd_h : even_h;
endmodule

// File: rtl/pfsel_splice.sv
module pfsel_splice
    import pfsel_pkg::*;
(
    input  logic [FRAME_BITS-1:0] pfn,
    input  logic [VA_BITS-1:0]    vaddr,
    input  logic [POS_BITS-1:0]   pos,
    output logic [OUT_BITS-1:0]   pa
);
    logic [PA_INT_BITS-1:0] frame_full;
    logic [PA_INT_BITS-1:0] low_keep;
    logic [PA_INT_BITS-1:0] joined;

    always_comb begin
        frame_full = {pfn, {MIN_PAGE_SHIFT{1'b0}}};
        low_keep   = (PA_INT_BITS'(1) << pos) - PA_INT_BITS'(1);
        joined     = (frame_full & ~low_keep) | (vaddr[PA_INT_BITS-1:0] & low_keep);
        pa         = OUT_BITS'(joined);
    end
endmodule

// File: rtl/pfsel_fault_gen.sv
module pfsel_fault_gen
    import pfsel_pkg::*;
(
    input  logic   hit,
    input  logic   is_store,
    input  logic   legal,
    input  half_t  chosen,
    output fault_e code
);
    always_comb begin
        if (!hit)
            code = is_store ? FC_REFILL_ST : FC_REFILL_LD;
        else if (!legal)
            code = FC_BAD_MASK;
        else if (!chosen.valid)
            code = is_store ? FC_INVALID_ST : FC_INVALID_LD;
        else if (is_store && !chosen.dirty)
            code = FC_MODIFY;
        else
            code = FC_NONE;
    end
endmodule

// File: rtl/pfsel_top.sv
module pfsel_top
    import pfsel_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hit,
    input  logic                  is_store,
    input  logic [VA_BITS-1:0]    vaddr,
    input  logic [MASK_BITS-1:0]  page_mask,
    input  logic [FRAME_BITS-1:0] even_pfn,
    input  logic                  even_valid,
    input  logic                  even_dirty,
    input  logic                  even_cap_st,
    input  logic                  even_cap_ld,
    input  logic [FRAME_BITS-1:0] odd_pfn,
    input  logic                  odd_valid,
    input  logic                  odd_dirty,
    input  logic                  odd_cap_st,
    input  logic                  odd_cap_ld,
    output logic [OUT_BITS-1:0]   phys_addr,
    output logic                  cap_ok,
    output logic                  fault,
    output logic [2:0]            fault_code
);
    half_t               even_h, odd_h, chosen;
    logic [POS_BITS-1:0] pos;
    logic                legal;
    logic [OUT_BITS-1:0] spliced;
    fault_e              code_d;
    result_t             res_d, res_q;

    assign even_h = '{pfn: even_pfn, valid: even_valid, dirty: even_dirty,
                      cap_st: even_cap_st, cap_ld: even_cap_ld};
    assign odd_h  = '{pfn: odd_pfn, valid: odd_valid, dirty: odd_dirty,
                      cap_st: odd_cap_st, cap_ld: odd_cap_ld};

    pfsel_mask_decode i_dec (
        .mask  (page_mask),
        .pos   (pos),
        .legal (legal)
    );

    pfsel_half_pick i_pick (
        .vaddr  (vaddr),
        .pos    (pos),
        .even_h (even_h),
        .odd_h  (odd_h),
        .chosen (chosen)
    );

    pfsel_splice i_splice (
        .pfn   (chosen.pfn),
        .vaddr (vaddr),
        .pos   (pos),
        .pa    (spliced)
    );

    pfsel_fault_gen i_fault (
        .hit      (hit),
        .is_store (is_store),
        .legal    (legal),
        .chosen   (chosen),
        .code     (code_d)
    );

    always_comb begin
        res_d.code = code_d;
        if (code_d == FC_NONE) begin
            res_d.pa  = spliced;
            res_d.cap = is_store ? chosen.cap_st : chosen.cap_ld;
        end else begin
            res_d.pa  = '0;
            res_d.cap = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '{pa: '0, cap: 1'b0, code: FC_NONE};
        else
            res_q <= res_d;
    end

    assign phys_addr  = res_q.pa;
    assign cap_ok     = res_q.cap;
    assign fault_code = res_q.code;
    assign fault      = (res_q.code != FC_NONE);
endmodule

// File: rtl/pfsel_checker.sv
module pfsel_checker
    import pfsel_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  hit,
    input logic                  is_store,
    input logic [VA_BITS-1:0]    vaddr,
    input logic [OUT_BITS-1:0]   phys_addr,
    input logic                  cap_ok,
    input logic                  fault,
    input logic [2:0]            fault_code
);
    logic live;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (phys_addr == '0 && !cap_ok && fault_code == 3'd0));

    // R12
    fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fault == (fault_code != 3'd0));

    // R12
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (phys_addr == '0 && !cap_ok));

    // R6
    refill_ld_chk: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!hit && !is_store)) |-> fault_code == 3'd1);

    // R6
    refill_st_chk: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!hit && is_store)) |-> fault_code == 3'd2);

    // R8
    load_no_modify_chk: assert property (@(posedge clk) disable iff (rst)
        (live && $past(!is_store)) |-> fault_code != 3'd5);

    // R5
    low_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !fault) |-> phys_addr[MIN_PAGE_SHIFT-1:0] == $past(vaddr[MIN_PAGE_SHIFT-1:0]));

    // R5
    high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OUT_BITS-1:PA_INT_BITS] == '0);
endmodule

bind pfsel_top pfsel_checker i_pfsel_checker (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .is_store   (is_store),
    .vaddr      (vaddr),
    .phys_addr  (phys_addr),
    .cap_ok     (cap_ok),
    .fault      (fault),
    .fault_code (fault_code)
);

// File: tb/test_pfsel_top.sv
module test_pfsel_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hit = 1'b0;
    logic        is_store = 1'b0;
    logic [63:0] vaddr = '0;
    logic [15:0] page_mask = '0;
    logic [23:0] even_pfn = '0, odd_pfn = '0;
    logic        even_valid = 0, even_dirty = 0, even_cap_st = 0, even_cap_ld = 0;
    logic        odd_valid = 0, odd_dirty = 0, odd_cap_st = 0, odd_cap_ld = 0;
    logic [63:0] phys_addr;
    logic        cap_ok, fault;
    logic [2:0]  fault_code;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfsel_top i_pfsel_top (
        .clk(clk), .rst(rst), .hit(hit), .is_store(is_store), .vaddr(vaddr),
        .page_mask(page_mask),
        .even_pfn(even_pfn), .even_valid(even_valid), .even_dirty(even_dirty),
        .even_cap_st(even_cap_st), .even_cap_ld(even_cap_ld),
        .odd_pfn(odd_pfn), .odd_valid(odd_valid), .odd_dirty(odd_dirty),
        .odd_cap_st(odd_cap_st), .odd_cap_ld(odd_cap_ld),
        .phys_addr(phys_addr), .cap_ok(cap_ok), .fault(fault), .fault_code(fault_code)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply at negedge, result registered at next posedge, sample at the following negedge.
    task automatic run_case(input logic h, input logic st, input logic [63:0] va,
                            input logic [15:0] m, input int sel, input logic legal);
        logic [2:0]  e_code;
        logic [63:0] e_pa;
        logic        e_cap, odd, v, d, cs, cl;
        logic [23:0] pfn;
        hit = h; is_store = st; vaddr = va; page_mask = m;
        @(posedge clk);
        @(negedge clk);
        odd = legal ? va[sel] : va[12];
        v   = odd ? odd_valid : even_valid;
        d   = odd ? odd_dirty : even_dirty;
        cs  = odd ? odd_cap_st : even_cap_st;
        cl  = odd ? odd_cap_ld : even_cap_ld;
        pfn = odd ? odd_pfn : even_pfn;
        if (!h)          e_code = st ? 3'd2 : 3'd1;
        else if (!legal) e_code = 3'd6;
        else if (!v)     e_code = st ? 3'd4 : 3'd3;
        else if (st && !d) e_code = 3'd5;
        else             e_code = 3'd0;
        if (e_code == 3'd0) begin
            e_pa  = (((64'(pfn) << 12) >> sel) << sel) | (va & ((64'd1 << sel) - 64'd1));
            e_cap = st ? cs : cl;
        end else begin
            e_pa  = '0;
            e_cap = 1'b0;
        end
        if (!h)               check("R6 refill code", 64'(fault_code), 64'(e_code));
        else if (!legal)      check("R11 bad mask code", 64'(fault_code), 64'(e_code));
        else if (!v)          check("R7/R9 invalid code", 64'(fault_code), 64'(e_code));
        else                  check("R8 modify/none code", 64'(fault_code), 64'(e_code));
        check("R12 fault flag", 64'(fault), 64'(e_code != 3'd0));
        if (e_code == 3'd0) check("R3/R4/R5 phys addr", phys_addr, e_pa);
        else                check("R12 zero addr on fault", phys_addr, 64'd0);
        check("R10 cap bit", 64'(cap_ok), 64'(e_cap));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        hit = 1'b1; vaddr = 64'hFFFF_FFFF_FFFF_FFFF;
        even_valid = 1; even_dirty = 1; even_cap_st = 1; even_cap_ld = 1; even_pfn = 24'hFFFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 reset addr", phys_addr, 64'd0);
        check("R1 reset code", 64'(fault_code), 64'd0);
        check("R1 reset cap", 64'(cap_ok), 64'd0);
        rst = 1'b0;
        // R1: first edge out of reset now captures real inputs; R2 latency checked in run_case
        for (int k = 0; k < 9; k++) begin
            for (int o = 0; o < 2; o++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int vd = 0; vd < 4; vd++) begin
                        int sel;
                        logic [63:0] va;
                        sel = 12 + 2 * k;
                        even_pfn = 24'hA5C3E1 ^ 24'(k * 24'h010203);
                        odd_pfn  = 24'h5A3C1E + 24'(k * 24'h111);
                        even_valid = vd[1]; even_dirty = vd[0];
                        odd_valid  = vd[1]; odd_dirty  = vd[0];
                        even_cap_st = k[0];  even_cap_ld = ~k[0];
                        odd_cap_st  = ~k[0] ^ vd[0]; odd_cap_ld = k[0] ^ vd[1];
                        va = 64'h0123_4567_89AB_CDEF ^ 64'(k * 64'h1357);
                        va[sel] = o[0];
                        run_case(1'b1, st[0], va, 16'((32'd1 << (2*k)) - 1), sel, 1'b1);
                    end
                end
            end
        end
        // R4: halves differ in validity -> selection visible in fault code
        even_valid = 1; even_dirty = 1; odd_valid = 0; odd_dirty = 0;
        run_case(1'b1, 1'b0, 64'h0000_0000_0001_0000, 16'h000F, 16, 1'b1);
        run_case(1'b1, 1'b0, 64'h0000_0000_0000_F000, 16'h000F, 16, 1'b1);
        // R9: invalid and clean store -> invalid-store wins
        even_valid = 0; even_dirty = 0;
        run_case(1'b1, 1'b1, 64'h0000_0000_0000_0000, 16'h0000, 12, 1'b1);
        // R6: misses, including with an illegal mask (R11 priority)
        even_valid = 1; even_dirty = 1;
        run_case(1'b0, 1'b0, 64'h1234, 16'h0003, 14, 1'b1);
        run_case(1'b0, 1'b1, 64'h1234, 16'h0003, 14, 1'b1);
        run_case(1'b0, 1'b1, 64'h1234, 16'h0007, 12, 1'b0);
        // R11: illegal masks on a hit
        run_case(1'b1, 1'b0, 64'h1234, 16'h0001, 12, 1'b0);
        run_case(1'b1, 1'b1, 64'h1234, 16'h00F0, 12, 1'b0);
        run_case(1'b1, 1'b0, 64'h1234, 16'h8000, 12, 1'b0);
        run_case(1'b1, 1'b0, 64'h1234, 16'h1FFF, 12, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule